// File: doc/BRIEF.md
# ECC Partial-Write Controller

This block fronts a single-port cache data RAM in which every 32-bit word is held together with seven SEC-DED check bits, so the RAM only ever accepts a whole 39-bit entry. Requesters issue reads and writes through one valid/ready port. A write carries an address, a data word and a per-byte enable mask.

When all enables are set, the word is encoded and stored in the same cycle it is accepted. Any other mask, whether one byte, a halfword or an irregular pattern, starts a two-cycle sequence. The controller reads the stored entry, corrects a single-bit error in it or detects a double-bit one, merges the enabled bytes, re-encodes the result and writes it back. The port stalls for one cycle while this happens.

Reads always fetch the whole entry and return the corrected word along with two status flags. A test input XORs a flip mask into every codeword on its way into the RAM, so that errors can be planted on purpose.

Top module: `ecc_merge_ctrl`

## Requirements
- R1: While reset is held, `req_ready_o`, `rd_valid_o`, `mrg_fix_o` and `mrg_abort_o` are low. Once reset has been released, `req_ready_o` is high.
- R2: A read accepted at clock edge k drives `rd_valid_o` high in the cycle that follows edge k. In that cycle `rd_data_o` is the last word written to that address, and both flags are low when the stored entry is clean.
- R3: A write whose enable mask is all ones (4'hF) keeps `req_ready_o` high, so a further request can be accepted at the very next edge.
- R4: For a write whose mask is not all ones, the stored word afterwards holds byte i of the new data (bits 8i+7..8i) wherever enable bit i is set, and the old byte everywhere else. `req_ready_o` is low for exactly the one cycle after acceptance.
- R5: A halfword mask (for example 4'b1100) follows the same merge-and-stall behaviour as a single-byte mask.
- R6: A read of an entry with one flipped bit returns the original data with `rd_corr_o` high and `rd_uncorr_o` low. This holds for any flipped bit. Bit 38 of the codeword is the overall parity bit, and bits 37..0 are Hamming positions 38..1.
- R7: A read of an entry with two flipped bits raises `rd_uncorr_o` and leaves `rd_corr_o` low.
- R8: A partial write over an entry with one flipped bit pulses `mrg_fix_o` in the stall cycle. It merges into the corrected word, so a later read returns the merged value with both flags low.
- R9: A partial write over an entry with two flipped bits pulses `mrg_abort_o` in the stall cycle and writes nothing. A later read of that address still reports `rd_uncorr_o`.
- R10: A read ignores `req_be_i` and always returns all four bytes.
- R11: A request presented while `req_ready_o` is low is not accepted and has no effect on the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 4 | Byte enables for writes |
| req_wdata_i | input | 32 | Write data |
| flip_mask_i | input | 39 | Bits XORed into the codeword written to the RAM |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Corrected read data |
| rd_corr_o | output | 1 | Read entry had a corrected single-bit error |
| rd_uncorr_o | output | 1 | Read entry had an uncorrectable error |
| mrg_fix_o | output | 1 | Merge corrected a single-bit error |
| mrg_abort_o | output | 1 | Merge aborted on a double-bit error |

## Verification
The bench builds the controller with ADDR_W = 3, an eight-word array, which keeps every stored word used by the tests easy to track. The RAM model's synchronous read is identical at any depth, so this value changes nothing in the timing of the stall cycle or the merge. Because flip masks are applied at the RAM write port, single and double errors can be planted both in Hamming data positions and in the overall parity bit. This brings correction on reads, correction inside a merge and the merge abort path within reach from the ports. A request held during the stall cycle exercises the back-pressure.

// File: rtl/ecc_merge_pkg.sv
package ecc_merge_pkg;
  localparam int DW = 32;          // protected data width
  localparam int PW = 6;           // Hamming check bits for DW
  localparam int HW = DW + PW;     // Hamming positions 1..HW
  localparam int CW = HW + 1;      // plus overall parity
  localparam int BW = DW / 8;      // byte lanes

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESP  = 2'd1,
    ST_MERGE = 2'd2
  } mst_e;
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
  import ecc_merge_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);
  logic [HW-1:0] h;

  always_comb begin
    int j;
    logic par;
    h = '0;
    j = 0;
    // data goes to every position that is not a power of two
    for (int i = 1; i <= HW; i++) begin
      if ((i & (i - 1)) != 0) begin
        h[i-1] = data_i[j];
        j++;
      end
    end
    // parity bit p covers the positions whose index has bit p set
    for (int p = 0; p < PW; p++) begin
      par = 1'b0;
      for (int i = 1; i <= HW; i++) begin
        if (((i >> p) & 1) == 1) par ^= h[i-1];
      end
      h[(1 << p) - 1] = par;
    end
    code_o = {^h, h};
  end
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
  import ecc_merge_pkg::*;
(
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          single_o,
  output logic          double_o
);
  logic [PW-1:0] syn;
  logic          odd;
  logic [HW-1:0] hf;

  always_comb begin
    int j;
    syn = '0;
    for (int i = 1; i <= HW; i++) begin
      if (code_i[i-1]) syn ^= PW'(i);
    end
    odd = ^code_i;
    single_o = odd && (int'(syn) <= HW);
    double_o = (!odd && (syn != '0)) || (odd && (int'(syn) > HW));
    hf = code_i[HW-1:0];
    if (single_o && (syn != '0)) hf[int'(syn) - 1] = ~hf[int'(syn) - 1];
    data_o = '0;
    j = 0;
    for (int i = 1; i <= HW; i++) begin
      if ((i & (i - 1)) != 0) begin
        data_o[j] = hf[i-1];
        j++;
      end
    end
  end
endmodule

// File: rtl/ecc_sp_ram.sv
module ecc_sp_ram #(
  parameter int AW = 6,
  parameter int W  = 39
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/ecc_merge_ctrl.sv
module ecc_merge_ctrl
  import ecc_merge_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BW-1:0]     req_be_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [CW-1:0]     flip_mask_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_corr_o,
  output logic              rd_uncorr_o,
  output logic              mrg_fix_o,
  output logic              mrg_abort_o
);
  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  mst_e st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     be_q;
  logic [DW-1:0]     wdata_q;
  logic [CW-1:0]     flip_q;

  logic accept, full, cap_en;
  logic ram_we, ram_re;
  logic [ADDR_W-1:0] ram_addr;
  logic [CW-1:0] ram_wdata, ram_rdata, enc_code;
  logic [DW-1:0] enc_in, dec_data, merged;
  logic dec_single, dec_double;
  logic in_merge;

  assign in_merge    = (st_q == ST_MERGE);
  assign req_ready_o = rst_n && !in_merge;
  assign accept      = req_valid_i && req_ready_o;
  assign full        = &req_be_i;
  assign cap_en      = accept && req_write_i && !full;

  // merge: enabled lanes from the request, the rest from the corrected word
  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign enc_in = in_merge ? merged : req_wdata_i;

  ecc_secded_enc i_enc (.data_i(enc_in), .code_o(enc_code));

  ecc_secded_dec i_dec (
    .code_i   (ram_rdata),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  // RAM port: one access per cycle
  always_comb begin
    if (in_merge) begin
      ram_we    = !dec_double;
      ram_re    = 1'b0;
      ram_addr  = addr_q;
      ram_wdata = enc_code ^ flip_q;
    end else begin
      ram_we    = accept && req_write_i && full;
      ram_re    = accept && (!req_write_i || !full);
      ram_addr  = req_addr_i;
      ram_wdata = enc_code ^ flip_mask_i;
    end
  end

  ecc_sp_ram #(.AW(ADDR_W), .W(CW)) i_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  // next state
  always_comb begin
    st_d = ST_IDLE;
    if (!in_merge) begin
      if (cap_en)                     st_d = ST_MERGE;
      else if (accept && !req_write_i) st_d = ST_RESP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // captured partial-write request, clock-enabled, no reset needed
  always_ff @(posedge clk_i) begin
    if (cap_en) begin
      addr_q  <= req_addr_i;
      be_q    <= req_be_i;
      wdata_q <= req_wdata_i;
      flip_q  <= flip_mask_i;
    end
  end

  assign rd_valid_o  = (st_q == ST_RESP);
  assign rd_data_o   = dec_data;
  assign rd_corr_o   = rd_valid_o && dec_single;
  assign rd_uncorr_o = rd_valid_o && dec_double;
  assign mrg_fix_o   = in_merge && dec_single;
  assign mrg_abort_o = in_merge && dec_double;
endmodule

// File: rtl/ecc_merge_chk.sv
module ecc_merge_chk
  import ecc_merge_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_write_i,
  input logic [BW-1:0] req_be_i,
  input logic          rd_valid_o,
  input logic          rd_corr_o,
  input logic          rd_uncorr_o,
  input logic          mrg_fix_o,
  input logic          mrg_abort_o,
  input logic          ram_we,
  input logic          ram_re
);
  // R4
  stall_after_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !req_ready_o |-> $past(req_valid_i && req_ready_o && req_write_i && !(&req_be_i)));

  // R2
  rd_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));

  // R3
  full_write_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_write_i && (&req_be_i)) |-> (ram_we && !ram_re));

  // R4
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({ram_we, ram_re}));

  // R7
  rd_flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(rd_corr_o && rd_uncorr_o));

  // R9
  abort_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    mrg_abort_o |-> !ram_we);

  // R8
  merge_flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(mrg_fix_o && mrg_abort_o));
endmodule

bind ecc_merge_ctrl ecc_merge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_be_i    (req_be_i),
  .rd_valid_o  (rd_valid_o),
  .rd_corr_o   (rd_corr_o),
  .rd_uncorr_o (rd_uncorr_o),
  .mrg_fix_o   (mrg_fix_o),
  .mrg_abort_o (mrg_abort_o),
  .ram_we      (ram_we),
  .ram_re      (ram_re)
);

// File: tb/test_ecc_merge_ctrl.sv
module test_ecc_merge_ctrl;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_be;
  logic [31:0]   req_wdata;
  logic [38:0]   flip;
  logic          rd_valid, rd_corr, rd_uncorr, mrg_fix, mrg_abort;
  logic [31:0]   rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // samples taken by the tasks
  logic        s_fix, s_abort, s_rdy, s_corr, s_unc;
  logic [31:0] s_data;

  always #2 clk = ~clk;

  ecc_merge_ctrl #(.ADDR_W(AW)) i_ecc_merge_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .flip_mask_i(flip),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_corr_o(rd_corr),
    .rd_uncorr_o(rd_uncorr), .mrg_fix_o(mrg_fix), .mrg_abort_o(mrg_abort)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_be = 4'h0; req_wdata = '0; flip = '0;
  endtask

  // write; call at a negedge, returns at a negedge with the controller idle
  task automatic do_write(input logic [AW-1:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic [38:0] f);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be;
    req_wdata = d; flip = f;
    @(posedge clk); @(negedge clk);
    s_rdy = req_ready; s_fix = mrg_fix; s_abort = mrg_abort;
    idle_inputs();
    if (be != 4'hF) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [3:0] be);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(posedge clk); @(negedge clk);
    s_data = rd_data; s_corr = rd_corr; s_unc = rd_uncorr;
    check(rd_valid === 1'b1, "R2 rd_valid", 32'(rd_valid), 32'd1);
    idle_inputs();
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0 && rd_valid === 1'b0 && mrg_fix === 1'b0 && mrg_abort === 1'b0,
          "R1 outputs in reset", {28'd0, req_ready, rd_valid, mrg_fix, mrg_abort}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_full();
    do_write(3'd1, 4'hF, 32'hDEADBEEF, '0);
    check(s_rdy === 1'b1, "R3 no stall on full write", 32'(s_rdy), 32'd1);
    do_read(3'd1, 4'hF);
    check(s_data === 32'hDEADBEEF && !s_corr && !s_unc, "R2 read back", s_data, 32'hDEADBEEF);
    // back-to-back full writes, accepted on consecutive edges
    req_valid = 1'b1; req_write = 1'b1; req_be = 4'hF; flip = '0;
    req_addr = 3'd2; req_wdata = 32'h01020304;
    @(posedge clk); @(negedge clk);
    check(req_ready === 1'b1, "R3 ready between full writes", 32'(req_ready), 32'd1);
    req_addr = 3'd3; req_wdata = 32'hA0B0C0D0;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    do_read(3'd2, 4'hF);
    check(s_data === 32'h01020304, "R3 first of pair", s_data, 32'h01020304);
    do_read(3'd3, 4'hF);
    check(s_data === 32'hA0B0C0D0, "R3 second of pair", s_data, 32'hA0B0C0D0);
  endtask

  task automatic t_partial();
    do_write(3'd4, 4'hF, 32'hA5A55A5A, '0);
    do_write(3'd4, 4'b0010, 32'h00003C00, '0);
    check(s_rdy === 1'b0, "R4 stall after byte write", 32'(s_rdy), 32'd0);
    check(req_ready === 1'b1, "R4 stall lasts one cycle", 32'(req_ready), 32'd1);
    do_read(3'd4, 4'hF);
    check(s_data === 32'hA5A53C5A, "R4 byte merge", s_data, 32'hA5A53C5A);
    do_write(3'd4, 4'b1100, 32'h12340000, '0);
    check(s_rdy === 1'b0, "R5 stall after halfword write", 32'(s_rdy), 32'd0);
    do_read(3'd4, 4'b0001);
    check(s_data === 32'h12343C5A, "R5 halfword merge", s_data, 32'h12343C5A);
    check(s_data[31:8] === 24'h12343C, "R10 read ignores be", s_data, 32'h12343C5A);
  endtask

  task automatic t_stall_ignore();
    do_write(3'd5, 4'hF, 32'h00000000, '0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd5; req_be = 4'b0001;
    req_wdata = 32'h00000077; flip = '0;
    @(posedge clk); @(negedge clk);
    // stall cycle: present a competing full write
    req_be = 4'hF; req_wdata = 32'hFFFFFFFF;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    do_read(3'd5, 4'hF);
    check(s_data === 32'h00000077, "R11 request in stall ignored", s_data, 32'h00000077);
  endtask

  task automatic t_read_errors();
    do_write(3'd6, 4'hF, 32'hCAFEF00D, 39'(1) << 20);
    do_read(3'd6, 4'hF);
    check(s_data === 32'hCAFEF00D && s_corr && !s_unc, "R6 single flip data bit",
          s_data, 32'hCAFEF00D);
    do_write(3'd6, 4'hF, 32'h13572468, 39'(1) << 38);
    do_read(3'd6, 4'hF);
    check(s_data === 32'h13572468 && s_corr && !s_unc, "R6 single flip parity bit",
          s_data, 32'h13572468);
    do_write(3'd6, 4'hF, 32'h0F0F0F0F, 39'(1) << 3);
    do_read(3'd6, 4'hF);
    check(s_data === 32'h0F0F0F0F && s_corr, "R6 single flip check bit", s_data, 32'h0F0F0F0F);
    do_write(3'd6, 4'hF, 32'h0F0F0F0F, (39'(1) << 3) | (39'(1) << 17));
    do_read(3'd6, 4'hF);
    check(s_unc && !s_corr, "R7 double flip detected", {30'd0, s_corr, s_unc}, 32'd1);
  endtask

  task automatic t_merge_errors();
    do_write(3'd7, 4'hF, 32'h11223344, 39'(1) << 10);
    do_write(3'd7, 4'b0001, 32'h000000AA, '0);
    check(s_fix === 1'b1 && s_abort === 1'b0, "R8 fix pulse", {30'd0, s_fix, s_abort}, 32'd2);
    do_read(3'd7, 4'hF);
    check(s_data === 32'h112233AA && !s_corr && !s_unc, "R8 merged clean", s_data, 32'h112233AA);
    do_write(3'd0, 4'hF, 32'h55667788, (39'(1) << 1) | (39'(1) << 30));
    do_write(3'd0, 4'b0011, 32'h0000BBBB, '0);
    check(s_abort === 1'b1 && s_fix === 1'b0, "R9 abort pulse", {30'd0, s_fix, s_abort}, 32'd1);
    do_read(3'd0, 4'hF);
    check(s_unc === 1'b1, "R9 entry left unchanged", 32'(s_unc), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    idle_inputs();
    @(negedge clk);
    t_reset();
    t_full();
    t_partial();
    t_stall_ignore();
    t_read_errors();
    t_merge_errors();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule